// File: doc/BRIEF.md
# Multi-Insert Hole-Filling Event Priority Queue

This block keeps the pending events of a discrete-event simulation pipeline in time order on chip. Each event carries a timestamp and two particle identifiers. The storage is a linear array of slots. Slot 0 is the front, and the valid slots are always in non-decreasing timestamp order. Every cycle the block can hand the earliest event to the consumer, accept up to `LANES` new events that land in their sorted places, and wipe out every stored event that names a broadcast particle identifier.

A wiped event leaves a hole in the array. Holes are not closed in one step. In each cycle, every surviving entry slides toward the front by the number of holes ahead of it, capped at two. The head output looks at the first three slots, so a hole or two at the front does not hide an event that sits just behind them. When the sorted result of a cycle would not fit in the array, the block raises a stall flag and takes none of that cycle's new events. Removal by pop and by kill still takes place in that cycle.

Top module: `event_sort_queue`

## Requirements
- R1: After synchronous reset the array holds no events: head_valid is 0 and stall is 0 while no lane is valid. Reset has priority over every other input in the same cycle.
- R2: Whenever any of slots 0, 1 or 2 holds an event, head_valid is 1 and the head fields show the first occupied one of those three slots, which is the earliest stored event.
- R3: When pop is 1 and head_valid is 1, the event shown on the head is removed at the clock edge. When head_valid is 0, pop has no effect.
- R4: Lane n (bits [n*16 +: 16] of ins_time, [n*8 +: 8] of ins_pa and of ins_pb) with ins_valid[n] set is stored in timestamp order in the same cycle. All LANES lanes may be valid in one cycle.
- R5: Events with equal timestamps leave in arrival order: an event already stored goes ahead of one that arrives later, and among lanes arriving in the same cycle the lower lane number goes first.
- R6: When kill_en is 1, every stored event whose first or second particle identifier equals kill_id is removed at that clock edge, however many events match.
- R7: In each cycle, every surviving entry moves toward the front by the number of empty slots ahead of it, limited to two. A run of more than two holes at the front can therefore leave the head empty for a cycle while events remain.
- R8: stall is 1 in a cycle when a lane is valid and the sorted result, computed after that cycle's pop and kill, would need a slot at index DEPTH or beyond. In that cycle no lane is accepted, and pop, kill and compaction proceed as usual.
- R9: A kill_id that matches no stored event, and lane data presented with ins_valid clear, leave the stored events unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pop | input | 1 | Remove the head event at this edge |
| ins_valid | input | LANES | Per-lane insert request |
| ins_time | input | LANES*16 | Per-lane timestamps, lane 0 in the low bits |
| ins_pa | input | LANES*8 | Per-lane first particle identifier |
| ins_pb | input | LANES*8 | Per-lane second particle identifier |
| kill_en | input | 1 | Remove all events that name kill_id |
| kill_id | input | 8 | Particle identifier to remove |
| head_valid | output | 1 | An event is shown on the head |
| head_time | output | 16 | Timestamp of the head event |
| head_pa | output | 8 | First particle identifier of the head event |
| head_pb | output | 8 | Second particle identifier of the head event |
| stall | output | 1 | This cycle's inserts are refused |

## Verification
The bench builds the queue with DEPTH = 8 and LANES = 4. With these values, four inserts into a half-full array fill it exactly, and a single further insert then overflows, which exercises both sides of the stall rule. The small array also allows a kill of five front entries to leave a three-slot hole run, which shows the two-slot advance limit as one cycle with an empty head. Tie ordering, kills that match on either identifier, and head lookahead past front holes are all driven through short event sequences whose results are worked out by hand.

// File: rtl/evq_pkg.sv
package evq_pkg;

    localparam int TS_W  = 16;
    localparam int PID_W = 8;

    typedef struct packed {
        logic             vld;
        logic [TS_W-1:0]  ts;
        logic [PID_W-1:0] pa;
        logic [PID_W-1:0] pb;
    } evq_slot_t;

    localparam evq_slot_t SLOT_EMPTY = '0;

    // entry is live and names the given particle
    function automatic logic slot_hit(evq_slot_t s, logic [PID_W-1:0] id);
        return s.vld && ((s.pa == id) || (s.pb == id));
    endfunction

    // hole counter saturating at the two-slot advance limit
    function automatic logic [1:0] sat_inc2(logic [1:0] h, logic inc);
        return (h == 2'd2) ? 2'd2 : h + {1'b0, inc};
    endfunction

endpackage

// File: rtl/evq_compact.sv
module evq_compact
    import evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  evq_slot_t src [DEPTH],
    output evq_slot_t dst [DEPTH]
);
    localparam int PAD = DEPTH + 2;

    evq_slot_t  pad [PAD];
    logic [1:0] gap [PAD];

    generate
        for (genvar i = 0; i < PAD; i++) begin : g_pad
            if (i < DEPTH) begin : g_live
                assign pad[i] = src[i];
            end else begin : g_tail
                assign pad[i] = SLOT_EMPTY;
            end
        end
    endgenerate

    // saturated count of holes in front of each slot
    always_comb begin
        gap[0] = 2'd0;
        for (int i = 0; i < PAD - 1; i++) begin
            gap[i + 1] = sat_inc2(gap[i], !pad[i].vld);
        end
    end

    // slot d receives the entry whose advance lands it on d
    always_comb begin
        for (int d = 0; d < DEPTH; d++) begin
            dst[d] = SLOT_EMPTY;
            for (int k = 0; k < 3; k++) begin
                if (pad[d + k].vld && (gap[d + k] == 2'(k))) begin
                    dst[d] = pad[d + k];
                end
            end
        end
    end

endmodule

// File: rtl/evq_insert.sv
module evq_insert
    import evq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LANES = 4
) (
    input  evq_slot_t        base_q  [DEPTH],
    input  logic [LANES-1:0] lane_vld,
    input  logic [TS_W-1:0]  lane_ts [LANES],
    input  logic [PID_W-1:0] lane_pa [LANES],
    input  logic [PID_W-1:0] lane_pb [LANES],
    output evq_slot_t        nxt_q   [DEPTH],
    output logic             full_stall
);
    localparam int POS_W = $clog2(DEPTH + LANES + 1);
    localparam int CNT_W = $clog2(LANES + 1);

    logic [POS_W-1:0] lane_pos [LANES];
    logic [POS_W-1:0] slot_pos [DEPTH];
    logic [LANES-1:0] lane_over;
    logic [DEPTH-1:0] slot_over;

    // destination of each new event: behind every stored event not later
    // than it, and behind lanes that sort ahead of it
    generate
        for (genvar n = 0; n < LANES; n++) begin : g_lane
            logic [CNT_W-1:0] rank;
            logic [POS_W-1:0] after;
            always_comb begin
                rank = '0;
                for (int m = 0; m < LANES; m++) begin
                    if (lane_vld[m] && ((lane_ts[m] < lane_ts[n]) ||
                        ((lane_ts[m] == lane_ts[n]) && (m < n)))) begin
                        rank = rank + CNT_W'(1);
                    end
                end
                after = '0;
                for (int p = 0; p < DEPTH; p++) begin
                    if (base_q[p].vld && (base_q[p].ts <= lane_ts[n])) begin
                        after = POS_W'(p + 1);
                    end
                end
                lane_pos[n]  = after + POS_W'(rank);
                lane_over[n] = lane_vld[n] && (lane_pos[n] >= POS_W'(DEPTH));
            end
        end

        // each stored event slides back by the lanes strictly earlier than it
        for (genvar p = 0; p < DEPTH; p++) begin : g_slot
            logic [CNT_W-1:0] shift;
            always_comb begin
                shift = '0;
                for (int m = 0; m < LANES; m++) begin
                    if (lane_vld[m] && (lane_ts[m] < base_q[p].ts)) begin
                        shift = shift + CNT_W'(1);
                    end
                end
                slot_pos[p]  = POS_W'(p) + POS_W'(shift);
                slot_over[p] = base_q[p].vld && (slot_pos[p] >= POS_W'(DEPTH));
            end
        end
    endgenerate

    assign full_stall = (|lane_over) || (|slot_over);

    always_comb begin
        for (int d = 0; d < DEPTH; d++) begin
            if (full_stall) begin
                nxt_q[d] = base_q[d];
            end else begin
                nxt_q[d] = SLOT_EMPTY;
                for (int p = 0; p < DEPTH; p++) begin
                    if (base_q[p].vld && (slot_pos[p] == POS_W'(d))) begin
                        nxt_q[d] = base_q[p];
                    end
                end
                for (int n = 0; n < LANES; n++) begin
                    if (lane_vld[n] && (lane_pos[n] == POS_W'(d))) begin
                        nxt_q[d].vld = 1'b1;
                        nxt_q[d].ts  = lane_ts[n];
                        nxt_q[d].pa  = lane_pa[n];
                        nxt_q[d].pb  = lane_pb[n];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/evq_head_pick.sv
module evq_head_pick
    import evq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  evq_slot_t               q [DEPTH],
    output logic                    found,
    output logic [$clog2(DEPTH)-1:0] idx,
    output evq_slot_t               slot
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int LOOK  = (DEPTH < 3) ? DEPTH : 3;

    // first occupied slot inside the front window
    always_comb begin
        found = 1'b0;
        idx   = '0;
        slot  = SLOT_EMPTY;
        for (int i = LOOK - 1; i >= 0; i--) begin
            if (q[i].vld) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                slot  = q[i];
            end
        end
    end

endmodule

// File: rtl/event_sort_queue.sv
module event_sort_queue
    import evq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     pop,
    input  logic [LANES-1:0]         ins_valid,
    input  logic [LANES*TS_W-1:0]    ins_time,
    input  logic [LANES*PID_W-1:0]   ins_pa,
    input  logic [LANES*PID_W-1:0]   ins_pb,
    input  logic                     kill_en,
    input  logic [PID_W-1:0]         kill_id,
    output logic                     head_valid,
    output logic [TS_W-1:0]          head_time,
    output logic [PID_W-1:0]         head_pa,
    output logic [PID_W-1:0]         head_pb,
    output logic                     stall
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + LANES + 1);
    localparam int LOOK  = (DEPTH < 3) ? DEPTH : 3;

    evq_slot_t q    [DEPTH];
    evq_slot_t work [DEPTH];
    evq_slot_t cmp  [DEPTH];
    evq_slot_t nxt  [DEPTH];

    logic [TS_W-1:0]  lane_ts [LANES];
    logic [PID_W-1:0] lane_pa [LANES];
    logic [PID_W-1:0] lane_pb [LANES];

    logic             hfound;
    logic [IDX_W-1:0] hidx;
    evq_slot_t        hslot;

    generate
        for (genvar n = 0; n < LANES; n++) begin : g_unpack
            assign lane_ts[n] = ins_time[n*TS_W +: TS_W];
            assign lane_pa[n] = ins_pa[n*PID_W +: PID_W];
            assign lane_pb[n] = ins_pb[n*PID_W +: PID_W];
        end
    endgenerate

    evq_head_pick #(.DEPTH(DEPTH)) u_head (
        .q     (q),
        .found (hfound),
        .idx   (hidx),
        .slot  (hslot)
    );

    assign head_valid = hfound;
    assign head_time  = hslot.ts;
    assign head_pa    = hslot.pa;
    assign head_pb    = hslot.pb;

    // removal stage: pop the shown head, then the associative kill
    always_comb begin
        work = q;
        if (pop && hfound) begin
            work[hidx].vld = 1'b0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (kill_en && slot_hit(work[i], kill_id)) begin
                work[i].vld = 1'b0;
            end
        end
    end

    evq_compact #(.DEPTH(DEPTH)) u_compact (
        .src (work),
        .dst (cmp)
    );

    evq_insert #(.DEPTH(DEPTH), .LANES(LANES)) u_insert (
        .base_q     (cmp),
        .lane_vld   (ins_valid),
        .lane_ts    (lane_ts),
        .lane_pa    (lane_pa),
        .lane_pb    (lane_pb),
        .nxt_q      (nxt),
        .full_stall (stall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) q[i] <= SLOT_EMPTY;
        end else begin
            q <= nxt;
        end
    end

    // ---------------- checks on the stage boundaries ----------------
    logic [CW-1:0] cnt_work, cnt_cmp, cnt_nxt, lanes_on;
    logic          kill_left, front_busy, order_ok;

    always_comb begin
        cnt_work  = '0;
        cnt_cmp   = '0;
        cnt_nxt   = '0;
        kill_left = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            cnt_work  = cnt_work + CW'(work[i].vld);
            cnt_cmp   = cnt_cmp + CW'(cmp[i].vld);
            cnt_nxt   = cnt_nxt + CW'(nxt[i].vld);
            kill_left = kill_left | slot_hit(cmp[i], kill_id);
        end
        lanes_on   = CW'($countones(ins_valid));
        front_busy = 1'b0;
        for (int i = 0; i < LOOK; i++) front_busy = front_busy | work[i].vld;
    end

    always_comb begin
        logic            seen;
        logic [TS_W-1:0] last;
        seen     = 1'b0;
        last     = '0;
        order_ok = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (q[i].vld) begin
                if (seen && (q[i].ts < last)) order_ok = 1'b0;
                seen = 1'b1;
                last = q[i].ts;
            end
        end
    end

    // R4
    lane_accept_chk: assert property (@(posedge clk) disable iff (rst)
        !stall |-> (cnt_nxt == cnt_cmp + lanes_on));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> ((cnt_nxt == cnt_cmp) && (ins_valid != '0)));

    // R5
    time_order_chk: assert property (@(posedge clk) disable iff (rst)
        order_ok);

    // R6
    kill_clear_chk: assert property (@(posedge clk) disable iff (rst)
        kill_en |-> !kill_left);

    // R7
    front_close_chk: assert property (@(posedge clk) disable iff (rst)
        front_busy |-> cmp[0].vld);

    // R7
    compact_keep_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_cmp == cnt_work);

endmodule

// File: tb/tb_event_sort_queue.sv
module tb_event_sort_queue;

    localparam int DEPTH = 8;
    localparam int LANES = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pop = 1'b0;
    logic [3:0]  ins_valid = '0;
    logic [63:0] ins_time = '0;
    logic [31:0] ins_pa = '0;
    logic [31:0] ins_pb = '0;
    logic        kill_en = 1'b0;
    logic [7:0]  kill_id = '0;
    logic        head_valid;
    logic [15:0] head_time;
    logic [7:0]  head_pa;
    logic [7:0]  head_pb;
    logic        stall;

    event_sort_queue #(.DEPTH(DEPTH), .LANES(LANES)) dut (
        .clk(clk), .rst(rst), .pop(pop),
        .ins_valid(ins_valid), .ins_time(ins_time),
        .ins_pa(ins_pa), .ins_pb(ins_pb),
        .kill_en(kill_en), .kill_id(kill_id),
        .head_valid(head_valid), .head_time(head_time),
        .head_pa(head_pa), .head_pb(head_pb), .stall(stall)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct packed {
        logic [3:0]  req;
        logic        pop;
        logic        ken;
        logic [7:0]  kid;
        logic [3:0]  lv;
        logic [63:0] lt;   // lane3..lane0
        logic [31:0] lpa;
        logic [31:0] lpb;
        logic        ehv;
        logic [15:0] eht;
        logic [7:0]  epa;
        logic        est;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        // R1 empty after reset, four lanes enter sorted
        '{4'd1, 1'b0, 1'b0, 8'd0, 4'b1111, {16'd10,16'd50,16'd20,16'd50}, {8'd7,8'd5,8'd3,8'd1}, {8'd8,8'd6,8'd4,8'd2}, 1'b0, 16'd0, 8'd0, 1'b0},
        // R4 earliest of the four
        '{4'd4, 1'b0, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd10, 8'd7, 1'b0},
        // R3 pop
        '{4'd3, 1'b1, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd10, 8'd7, 1'b0},
        // R4
        '{4'd4, 1'b1, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd20, 8'd3, 1'b0},
        // R5 lane 0 ahead of lane 2 on equal time; new 50 arrives
        '{4'd5, 1'b1, 1'b0, 8'd0, 4'b0001, {48'd0,16'd50}, {24'd0,8'd9}, {24'd0,8'd10}, 1'b1, 16'd50, 8'd1, 1'b0},
        // R5 older 50 ahead of newer 50
        '{4'd5, 1'b1, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd50, 8'd5, 1'b0},
        // R4 four lanes around a stored event
        '{4'd4, 1'b0, 1'b0, 8'd0, 4'b1111, {16'd70,16'd60,16'd40,16'd30}, {8'd17,8'd15,8'd13,8'd11}, {8'd18,8'd16,8'd14,8'd12}, 1'b1, 16'd50, 8'd9, 1'b0},
        // R6 kill by second identifier
        '{4'd6, 1'b0, 1'b1, 8'd14, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd30, 8'd11, 1'b0},
        // R8 exactly fills the array
        '{4'd8, 1'b0, 1'b0, 8'd0, 4'b1111, {16'd110,16'd100,16'd90,16'd80}, {8'd26,8'd40,8'd22,8'd40}, {8'd27,8'd25,8'd40,8'd21}, 1'b1, 16'd30, 8'd11, 1'b0},
        // R8 one more overflows
        '{4'd8, 1'b0, 1'b0, 8'd0, 4'b0010, {32'd0,16'd5,16'd0}, {16'd0,8'd31,8'd0}, {16'd0,8'd32,8'd0}, 1'b1, 16'd30, 8'd11, 1'b1},
        // R8 previous refused; pop frees room in the same cycle
        '{4'd8, 1'b1, 1'b0, 8'd0, 4'b0010, {32'd0,16'd5,16'd0}, {16'd0,8'd31,8'd0}, {16'd0,8'd32,8'd0}, 1'b1, 16'd30, 8'd11, 1'b0},
        // R4
        '{4'd4, 1'b0, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd5, 8'd31, 1'b0},
        // R6 kill three at once plus pop
        '{4'd6, 1'b1, 1'b1, 8'd40, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd5, 8'd31, 1'b0},
        // R6
        '{4'd6, 1'b1, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd50, 8'd9, 1'b0},
        // R7
        '{4'd7, 1'b1, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd60, 8'd15, 1'b0},
        // R7
        '{4'd7, 1'b1, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd70, 8'd17, 1'b0},
        // R6 80, 90, 100 are gone
        '{4'd6, 1'b1, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd110, 8'd26, 1'b0},
        // R3 empty; refill
        '{4'd3, 1'b0, 1'b0, 8'd0, 4'b1111, {16'd4,16'd3,16'd2,16'd1}, {8'd54,8'd50,8'd52,8'd50}, {8'd55,8'd53,8'd50,8'd51}, 1'b0, 16'd0, 8'd0, 1'b0},
        // R6 kill id 50 on either field
        '{4'd6, 1'b0, 1'b1, 8'd50, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd1, 8'd50, 1'b0},
        // R2 survivor seen behind a front hole, then popped
        '{4'd2, 1'b1, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd4, 8'd54, 1'b0},
        // R3
        '{4'd3, 1'b0, 1'b0, 8'd0, 4'b0001, {48'd0,16'd7}, {24'd0,8'd60}, {24'd0,8'd61}, 1'b0, 16'd0, 8'd0, 1'b0},
        // R9 kill with no match
        '{4'd9, 1'b0, 1'b1, 8'd99, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd7, 8'd60, 1'b0},
        // R9
        '{4'd9, 1'b1, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd7, 8'd60, 1'b0},
        // R3
        '{4'd3, 1'b0, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b0, 16'd0, 8'd0, 1'b0},
        // R4 four events sharing id 70
        '{4'd4, 1'b0, 1'b0, 8'd0, 4'b1111, {16'd14,16'd13,16'd12,16'd11}, {8'd70,8'd70,8'd70,8'd70}, {8'd4,8'd3,8'd2,8'd1}, 1'b0, 16'd0, 8'd0, 1'b0},
        // R4
        '{4'd4, 1'b0, 1'b0, 8'd0, 4'b0011, {32'd0,16'd16,16'd15}, {16'd0,8'd71,8'd70}, {16'd0,8'd6,8'd5}, 1'b1, 16'd11, 8'd70, 1'b0},
        // R6 five front entries killed
        '{4'd6, 1'b0, 1'b1, 8'd70, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd11, 8'd70, 1'b0},
        // R7 survivor only advanced two slots: head empty
        '{4'd7, 1'b0, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b0, 16'd0, 8'd0, 1'b0},
        // R7 now visible
        '{4'd7, 1'b1, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b1, 16'd16, 8'd71, 1'b0},
        // R3
        '{4'd3, 1'b0, 1'b0, 8'd0, 4'b0000, 64'd0, 32'd0, 32'd0, 1'b0, 16'd0, 8'd0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        pop = 1'b0; kill_en = 1'b0; kill_id = '0;
        ins_valid = '0; ins_time = '0; ins_pa = '0; ins_pb = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pop       = VEC[v].pop;
            kill_en   = VEC[v].ken;
            kill_id   = VEC[v].kid;
            ins_valid = VEC[v].lv;
            ins_time  = VEC[v].lt;
            ins_pa    = VEC[v].lpa;
            ins_pb    = VEC[v].lpb;
            #1;
            chk($sformatf("R%0d vec%0d head_valid", VEC[v].req, v), 32'(head_valid), 32'(VEC[v].ehv));
            if (VEC[v].ehv) begin
                chk($sformatf("R%0d vec%0d head_time", VEC[v].req, v), 32'(head_time), 32'(VEC[v].eht));
                chk($sformatf("R%0d vec%0d head_pa", VEC[v].req, v), 32'(head_pa), 32'(VEC[v].epa));
            end
            chk($sformatf("R%0d vec%0d stall", VEC[v].req, v), 32'(stall), 32'(VEC[v].est));
        end

        // R9: lane data with ins_valid clear and kill_en clear are ignored
        @(negedge clk);
        idle();
        ins_valid = 4'b0001; ins_time = 64'd20; ins_pa = 32'd80; ins_pb = 32'd81;
        @(negedge clk);
        idle();
        ins_time = '1; ins_pa = '1; ins_pb = '1; kill_id = 8'd80;
        #1;
        chk("R9 stall with lanes idle", 32'(stall), 32'd0);
        @(negedge clk);
        idle();
        #1;
        chk("R9 head_valid kept", 32'(head_valid), 32'd1);
        chk("R9 head_time kept", 32'(head_time), 32'd20);
        chk("R9 head_pa kept", 32'(head_pa), 32'd80);
        chk("R2 head_pb shown", 32'(head_pb), 32'd81);

        // R1: reset wins over a same-cycle insert and clears the store
        @(negedge clk);
        rst = 1'b1;
        ins_valid = 4'b0001; ins_time = 64'd3; ins_pa = 32'd9; ins_pb = 32'd9;
        @(negedge clk);
        rst = 1'b0;
        idle();
        #1;
        chk("R1 head_valid after reset", 32'(head_valid), 32'd0);
        chk("R1 stall after reset", 32'(stall), 32'd0);

        // R4: store works again after reset
        @(negedge clk);
        ins_valid = 4'b1000; ins_time = {16'd33, 48'd0}; ins_pa = {8'd44, 24'd0}; ins_pb = '0;
        @(negedge clk);
        idle();
        #1;
        chk("R4 lane 3 stored after reset", 32'(head_time), 32'd33);
        chk("R4 lane 3 identifier", 32'(head_pa), 32'd44);

        finish_run();
    end

endmodule